// File: doc/BRIEF.md
# MD5 Step Datapath

This block performs a single compression step of the MD5 hash on a set of four 32-bit chaining words. Its inputs are the current words A, B, C and D, a 2-bit round selector, the additive table constant, the message word picked for this step, and a 5-bit rotate amount. Its outputs are the four words after the step, already shifted into the order the next step expects. All four nonlinear round functions and a rotator that takes its amount at run time sit in one datapath. One instance can therefore serve all 64 steps of an iterative hash engine, with an outside sequencer supplying the round, constant, message word and amount for each step.

The arithmetic is a purely combinational core. A thin wrapper registers the four result words so that the core's path can be timed between flops. The step counter, the constant and schedule tables, the message buffer and the final feed-forward addition of the chaining values all sit outside the block.

Top module: `md_step_unit`

## Requirements
- R1: The new word equals B + rotl(A + f(B,C,D) + X + T, s), where X is the message word, T the constant, s the rotate amount and f the selected round function.
- R2: The output order is a_out = D, b_out = the new word, c_out = B and d_out = C.
- R3: Selector value 2'b00 picks f = (B & C) | (~B & D).
- R4: Selector value 2'b01 picks f = (B & D) | (C & ~D).
- R5: Selector value 2'b10 picks f = B ^ C ^ D.
- R6: Selector value 2'b11 picks f = C ^ (B | ~D).
- R7: The rotation is circular toward the MSB and is correct for every amount from 0 to 31, including amounts no MD5 step uses. An amount of 0 leaves the sum unchanged.
- R8: All four outputs are registered. They show the result for inputs held across a rising clock edge from that edge on, and they do not change between edges. A synchronous active-high reset clears all four outputs to zero.
- R9: Every addition is modulo 2^32, so the carry out of bit 31 is dropped, as seen with all-ones operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 32 | Chaining word A |
| b_in | input | 32 | Chaining word B |
| c_in | input | 32 | Chaining word C |
| d_in | input | 32 | Chaining word D |
| rnd_sel | input | 2 | Round function select: 00 F, 01 G, 10 H, 11 I |
| k_const | input | 32 | Additive table constant for this step |
| msg_word | input | 32 | Message word for this step |
| rot_amt | input | 5 | Left rotate amount |
| a_out | output | 32 | Registered next A (previous D) |
| b_out | output | 32 | Registered next B (new word) |
| c_out | output | 32 | Registered next C (previous B) |
| d_out | output | 32 | Registered next D (previous C) |

## Verification
Each selector value is driven with pseudo-random operands and compared with an independent model. A wrong branch in the function multiplexer, or one function swapped for another, therefore shows up as a wrong new word.

A sweep over all 32 rotate amounts with one fixed sum separates a correct circular rotation from a plain shift, from a rotation in the wrong direction, and from a broken stage of the rotator.

All-ones and all-zeros operands show whether carries wrap. A vector with four distinct words shows whether the outputs come out in the wrong order. Checks made before and after a clock edge separate registered outputs from a leak through the combinational path.

// File: rtl/md_step_pkg.sv
package md_step_pkg;

  typedef enum logic [1:0] {
    RND_F = 2'b00,
    RND_G = 2'b01,
    RND_H = 2'b10,
    RND_I = 2'b11
  } round_e;

endpackage

// File: rtl/md_mix_fn.sv
module md_mix_fn
  import md_step_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [WORD_W-1:0] x,
  input  logic [WORD_W-1:0] y,
  input  logic [WORD_W-1:0] z,
  output logic [WORD_W-1:0] f
);

  logic [WORD_W-1:0] f_sel, g_sel, h_par, i_mix;

  // The four round functions are computed side by side, then one is picked.
  always_comb begin
    f_sel = (x & y) | (~x & z);
    g_sel = (x & z) | (y & ~z);
    h_par = x ^ y ^ z;
    i_mix = y ^ (x | ~z);
  end

  always_comb begin
    unique case (round_e'(sel))
      RND_F:   f = f_sel;
      RND_G:   f = g_sel;
      RND_H:   f = h_par;
      default: f = i_mix;
    endcase
  end

endmodule

// File: rtl/md_rotl.sv
module md_rotl #(
  parameter int WORD_W = 32,
  localparam int ROT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] din,
  input  logic [ROT_W-1:0]  amt,
  output logic [WORD_W-1:0] dout
);

  logic [ROT_W:0][WORD_W-1:0] stage;

  assign stage[0] = din;

  // Log-depth barrel: stage k rotates by 2**k when bit k of the amount is set.
  for (genvar k = 0; k < ROT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt[k] ?
      {stage[k][WORD_W-1-SH:0], stage[k][WORD_W-1:WORD_W-SH]} : stage[k];
  end

  assign dout = stage[ROT_W];

endmodule

// File: rtl/md_step_core.sv
module md_step_core
  import md_step_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int ROT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] c,
  input  logic [WORD_W-1:0] d,
  input  logic [1:0]        rnd,
  input  logic [WORD_W-1:0] t,
  input  logic [WORD_W-1:0] x,
  input  logic [ROT_W-1:0]  s,
  output logic [WORD_W-1:0] a_nx,
  output logic [WORD_W-1:0] b_nx,
  output logic [WORD_W-1:0] c_nx,
  output logic [WORD_W-1:0] d_nx
);

  logic [WORD_W-1:0] f_val;
  logic [WORD_W-1:0] sum_ax, sum_tf, pre_sum, rot_val;

  md_mix_fn #(.WORD_W(WORD_W)) u_mix (
    .sel (rnd),
    .x   (b),
    .y   (c),
    .z   (d),
    .f   (f_val)
  );

  // Two balanced adders feed the third; the carry out of the top bit is dropped.
  always_comb begin
    sum_ax  = a + x;
    sum_tf  = t + f_val;
    pre_sum = sum_ax + sum_tf;
  end

  md_rotl #(.WORD_W(WORD_W)) u_rot (
    .din  (pre_sum),
    .amt  (s),
    .dout (rot_val)
  );

  always_comb begin
    a_nx = d;
    b_nx = b + rot_val;
    c_nx = b;
    d_nx = c;
  end

  always_comb begin
    if (!$isunknown({a, b, c, d, rnd, t, x, s})) begin
      // R7: a zero amount leaves the sum untouched
      if (s == '0) assert_rot_zero_pass_R7: assert (rot_val == pre_sum);
      // R7: rotation only moves bits, it never creates or drops them
      assert_rot_keeps_ones_R7: assert ($countones(rot_val) == $countones(pre_sum));
      // R3: with B all ones, the first function passes C
      if (rnd == RND_F && b == '1) assert_fsel_b_ones_R3: assert (f_val == c);
      // R6: with D all zeros, the last function is the complement of C
      if (rnd == RND_I && d == '0) assert_imix_d_zero_R6: assert (f_val == ~c);
    end
  end

endmodule

// File: rtl/md_step_unit.sv
module md_step_unit #(
  parameter int WORD_W = 32,
  localparam int ROT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] a_in,
  input  logic [WORD_W-1:0] b_in,
  input  logic [WORD_W-1:0] c_in,
  input  logic [WORD_W-1:0] d_in,
  input  logic [1:0]        rnd_sel,
  input  logic [WORD_W-1:0] k_const,
  input  logic [WORD_W-1:0] msg_word,
  input  logic [ROT_W-1:0]  rot_amt,
  output logic [WORD_W-1:0] a_out,
  output logic [WORD_W-1:0] b_out,
  output logic [WORD_W-1:0] c_out,
  output logic [WORD_W-1:0] d_out
);

  logic [WORD_W-1:0] a_nx, b_nx, c_nx, d_nx;

  md_step_core #(.WORD_W(WORD_W)) u_core (
    .a    (a_in),
    .b    (b_in),
    .c    (c_in),
    .d    (d_in),
    .rnd  (rnd_sel),
    .t    (k_const),
    .x    (msg_word),
    .s    (rot_amt),
    .a_nx (a_nx),
    .b_nx (b_nx),
    .c_nx (c_nx),
    .d_nx (d_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      b_out <= '0;
      c_out <= '0;
      d_out <= '0;
    end else begin
      a_out <= a_nx;
      b_out <= b_nx;
      c_out <= c_nx;
      d_out <= d_nx;
    end
  end

  // R8: one edge after reset is seen, every output is zero
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b_out == '0 && c_out == '0 && d_out == '0));

  // R2: the moved words leave one edge after they were presented
  assert_word_order_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (a_out == $past(d_in) && c_out == $past(b_in) && d_out == $past(c_in)));

endmodule

// File: tb/test_md_step_unit.sv
module test_md_step_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a_in = '0, b_in = '0, c_in = '0, d_in = '0;
  logic [1:0]  rnd_sel = '0;
  logic [31:0] k_const = '0, msg_word = '0;
  logic [4:0]  rot_amt = '0;
  logic [31:0] a_out, b_out, c_out, d_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  md_step_unit i_md_step_unit (
    .clk, .rst, .a_in, .b_in, .c_in, .d_in, .rnd_sel,
    .k_const, .msg_word, .rot_amt, .a_out, .b_out, .c_out, .d_out
  );

  function automatic logic [31:0] ref_fn(logic [1:0] sel, logic [31:0] b, logic [31:0] c, logic [31:0] d);
    case (sel)
      2'd0:    return (b & c) | (~b & d);
      2'd1:    return (b & d) | (c & ~d);
      2'd2:    return b ^ c ^ d;
      default: return c ^ (b | ~d);
    endcase
  endfunction

  function automatic logic [31:0] ref_rotl(logic [31:0] v, logic [4:0] s);
    logic [63:0] w;
    w = {v, v} << s;
    return w[63:32];
  endfunction

  function automatic logic [31:0] ref_new(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                          logic [31:0] d, logic [1:0] sel, logic [31:0] t,
                                          logic [31:0] x, logic [4:0] s);
    logic [31:0] sum;
    sum = a + ref_fn(sel, b, c, d) + x + t;
    return b + ref_rotl(sum, s);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge (one register).
  task automatic run_vec(string tag, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                         logic [31:0] d, logic [1:0] sel, logic [31:0] t,
                         logic [31:0] x, logic [4:0] s);
    @(negedge clk);
    a_in = a; b_in = b; c_in = c; d_in = d;
    rnd_sel = sel; k_const = t; msg_word = x; rot_amt = s;
    @(negedge clk);
    check(tag, b_out, ref_new(a, b, c, d, sel, t, x, s));
    check("R2 a_out", a_out, d);
    check("R2 c_out", c_out, b);
    check("R2 d_out", d_out, c);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    a_in = 32'h1111_1111; b_in = 32'h2222_2222; c_in = 32'h3333_3333; d_in = 32'h4444_4444;
    @(negedge clk);
    @(negedge clk);
    check("R8 reset a", a_out, '0);
    check("R8 reset b", b_out, '0);
    check("R8 reset c", c_out, '0);
    check("R8 reset d", d_out, '0);
    rst = 1'b0;
  endtask

  task automatic t_round(logic [1:0] sel, string tag);
    logic [4:0] amts [4] = '{5'd7, 5'd12, 5'd17, 5'd22};
    for (int i = 0; i < 8; i++)
      run_vec(tag, $urandom, $urandom, $urandom, $urandom, sel, $urandom, $urandom, amts[i%4]);
  endtask

  task automatic t_rotate_sweep;
    for (int s = 0; s < 32; s++)
      run_vec("R7 rotate amount", 32'h0000_0081, 32'h0, 32'h0, 32'h0, 2'd2, 32'h0, 32'h0, 5'(s));
    run_vec("R7 zero amount", 32'h8765_4321, 32'h0, 32'h0, 32'h0, 2'd2, 32'h0, 32'h0, 5'd0);
  endtask

  task automatic t_carry;
    run_vec("R9 all ones F", '1, '1, '1, '1, 2'd0, '1, '1, 5'd0);
    run_vec("R9 all ones I", '1, '1, '1, '1, 2'd3, '1, '1, 5'd21);
    run_vec("R9 all zeros G", '0, '0, '0, '0, 2'd1, '0, '0, 5'd9);
    run_vec("R1 mixed", 32'h6745_2301, 32'hefcd_ab89, 32'h98ba_dcfe, 32'h1032_5476,
            2'd0, 32'hd76a_a478, 32'h0000_0080, 5'd7);
  endtask

  task automatic t_order;
    run_vec("R1 order", 32'hAAAA_0001, 32'hBBBB_0002, 32'hCCCC_0003, 32'hDDDD_0004,
            2'd2, 32'h1, 32'h2, 5'd4);
  endtask

  task automatic t_latency;
    logic [31:0] held;
    @(negedge clk);
    held = b_out;
    a_in = a_in + 32'h0101_0101;
    #1;
    check("R8 held between edges", b_out, held);
    @(negedge clk);
    check("R8 updated at edge", b_out,
          ref_new(a_in, b_in, c_in, d_in, rnd_sel, k_const, msg_word, rot_amt));
  endtask

  initial begin
    t_reset();
    t_round(2'd0, "R3 round F");
    t_round(2'd1, "R4 round G");
    t_round(2'd2, "R5 round H");
    t_round(2'd3, "R6 round I");
    t_rotate_sweep();
    t_carry();
    t_order();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule